// File: doc/BRIEF.md
# Terminal Cursor Movement Controller

This block tracks the cursor cell of a character-cell video terminal as characters arrive. Two data-available strobes, one from each receive path, start an event. A phase code from the timing sequencer selects two points in each event. In the latch phase the character on the bus is classified and the result is stored. In the move phase the cursor is updated once.

A printable character is taken to have been written at the cursor, so the cursor then steps one cell to the right. At the end of a row it wraps to column 0 of the next row. Carriage return, line feed and backspace each run their own counter operation in place of that step. Any other control code, and rubout, leave the cursor where it is. A separate defeat input blocks the automatic step without affecting the dedicated moves.

Top module: `cursor_ctrl`

## Requirements
- R1: An event starts on the rising edge of the OR of `dav_a_i` and `dav_b_i`, so either strobe alone drives the full behaviour.
- R2: While `rst_ni` is low, `col_o` and `row_o` are 0.
- R3: A printable character (code 0x20 to 0x7E) advances `col_o` by one, in the clock edge that samples the move phase (`phase_i` = 2) with data available.
- R4: A column advance from COLS-1 (default 79) gives column 0 and row+1. The row counts modulo ROWS (default 12), so row ROWS-1 becomes 0.
- R5: Carriage return (0x0D) sets the column to 0 and leaves the row unchanged.
- R6: Line feed (0x0A) increments the row modulo ROWS and leaves the column unchanged.
- R7: Backspace (0x08) decrements the column. At column 0 the column stays 0 and the row does not change.
- R8: Any other code below 0x20, and rubout (0x7F), leave both counters unchanged.
- R9: While `adv_defeat_i` is high, the automatic advance of R3 and R4 does not happen. Carriage return, line feed and backspace still act.
- R10: The counters change only on an edge that samples `phase_i` = 2 with data available. The character class is captured on an edge that samples `phase_i` = 1 with data available. All other phase codes are idle.
- R11: The captured class is cleared at the start of every event. A move phase reached without a latch phase in the current event is therefore treated as a printable advance.
- R12: At most one cursor move happens per event, however many move phases occur while data available stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dav_a_i | input | 1 | Data-available strobe, first receive path |
| dav_b_i | input | 1 | Data-available strobe, second receive path |
| char_i | input | 7 | Character code on the bus |
| phase_i | input | 3 | Sequencer phase code (1 latch, 2 move) |
| adv_defeat_i | input | 1 | Blocks the automatic post-write advance |
| col_o | output | COL_W | Cursor column |
| row_o | output | ROW_W | Cursor row |

## Verification
Every result is due one clock edge after its cause. The class is captured on the edge that samples the latch phase. The counters change on the edge that samples the move phase, and the new position is visible from that edge onward. The bench drives inputs on falling edges. A behavioural model steps on each rising edge, and the outputs are compared with it at every falling edge. Directed checks run after each character sequence has returned to the idle phase. Between those points the per-cycle comparison shows that idle, latch-only and repeated move phases leave the position untouched.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int PHASE_W  = 3;
  localparam int CHAR_W   = 7;
  localparam logic [PHASE_W-1:0] PH_LATCH = 3'd1;
  localparam logic [PHASE_W-1:0] PH_MOVE  = 3'd2;
  localparam logic [CHAR_W-1:0]  CH_BS    = 7'h08;
  localparam logic [CHAR_W-1:0]  CH_LF    = 7'h0A;
  localparam logic [CHAR_W-1:0]  CH_CR    = 7'h0D;
  localparam logic [CHAR_W-1:0]  CH_DEL   = 7'h7F;
  localparam logic [CHAR_W-1:0]  CH_SPACE = 7'h20;

  typedef struct packed {
    logic ctl;
    logic cr;
    logic lf;
    logic bs;
  } ch_class_t;
endpackage

// File: rtl/cursor_decode.sv
module cursor_decode
  import cursor_pkg::*;
(
  input  logic [CHAR_W-1:0] char_i,
  output ch_class_t         class_o
);
  always_comb begin
    class_o     = '0;
    class_o.ctl = (char_i < CH_SPACE) || (char_i == CH_DEL);
    class_o.cr  = (char_i == CH_CR);
    class_o.lf  = (char_i == CH_LF);
    class_o.bs  = (char_i == CH_BS);
  end
endmodule

// File: rtl/cursor_event.sv
module cursor_event
  import cursor_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      dav_a_i,
  input  logic      dav_b_i,
  input  logic      latch_i,
  input  logic      move_i,
  input  ch_class_t class_i,
  output ch_class_t class_o,
  output logic      act_o
);
  logic      dav_any, dav_q, rise, done_q, done_eff;
  ch_class_t class_q;

  assign dav_any  = dav_a_i | dav_b_i;
  assign rise     = dav_any & ~dav_q;
  assign done_eff = done_q & ~rise;
  assign class_o  = rise ? '0 : class_q;
  assign act_o    = move_i & dav_any & ~done_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dav_q   <= 1'b0;
      done_q  <= 1'b0;
      class_q <= '0;
    end else begin
      dav_q <= dav_any;
      if (rise) begin
        done_q  <= 1'b0;
        class_q <= '0;
      end
      if (latch_i && dav_any) class_q <= class_i;
      if (act_o) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cursor_counters.sv
module cursor_counters
  import cursor_pkg::*;
#(
  parameter int COLS  = 80,
  parameter int ROWS  = 12,
  parameter int COL_W = $clog2(COLS),
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  ch_class_t        class_i,
  input  logic             defeat_i,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q, row_inc;

  assign row_inc = (row_q == ROW_LAST) ? '0 : row_q + ROW_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (act_i) begin
      if (class_i.ctl) begin
        if (class_i.cr) col_q <= '0;
        if (class_i.bs && col_q != '0) col_q <= col_q - COL_W'(1);
        if (class_i.lf) row_q <= row_inc;
      end else if (!defeat_i) begin
        if (col_q == COL_LAST) begin
          col_q <= '0;
          row_q <= row_inc;
        end else begin
          col_q <= col_q + COL_W'(1);
        end
      end
    end
  end

  assign col_o = col_q;
  assign row_o = row_q;
endmodule

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
#(
  parameter int COLS  = 80,
  parameter int ROWS  = 12,
  parameter int COL_W = $clog2(COLS),
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dav_a_i,
  input  logic               dav_b_i,
  input  logic [6:0]         char_i,
  input  logic [2:0]         phase_i,
  input  logic               adv_defeat_i,
  output logic [COL_W-1:0]   col_o,
  output logic [ROW_W-1:0]   row_o
);
  ch_class_t dec_class, evt_class;
  logic      act;

  cursor_decode u_dec (
    .char_i  (char_i),
    .class_o (dec_class)
  );

  cursor_event u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dav_a_i (dav_a_i),
    .dav_b_i (dav_b_i),
    .latch_i (phase_i == PH_LATCH),
    .move_i  (phase_i == PH_MOVE),
    .class_i (dec_class),
    .class_o (evt_class),
    .act_o   (act)
  );

  cursor_counters #(.COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (act),
    .class_i  (evt_class),
    .defeat_i (adv_defeat_i),
    .col_o    (col_o),
    .row_o    (row_o)
  );
endmodule

// File: rtl/cursor_ctrl_chk.sv
module cursor_ctrl_chk #(
  parameter int COLS  = 80,
  parameter int ROWS  = 12,
  parameter int COL_W = $clog2(COLS),
  parameter int ROW_W = $clog2(ROWS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dav_a_i,
  input logic             dav_b_i,
  input logic [2:0]       phase_i,
  input logic [COL_W-1:0] col_o,
  input logic [ROW_W-1:0] row_o
);
  logic dav_any, mv;
  assign dav_any = dav_a_i | dav_b_i;
  assign mv      = (phase_i == 3'd2);

  assert_reset_zero_R2: assert property (@(posedge clk_i)
    !rst_ni |-> (col_o == '0 && row_o == '0));

  assert_col_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(col_o) < COLS) && (int'(row_o) < ROWS));

  assert_quiet_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mv && dav_any) |=> ($stable(col_o) && $stable(row_o)));

  assert_one_move_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dav_any && mv) ##1 dav_any |=> ($stable(col_o) && $stable(row_o)));

  assert_col_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(col_o) |-> (col_o == '0 || col_o == COL_W'($past(col_o) + COL_W'(1))
                         || COL_W'(col_o + COL_W'(1)) == $past(col_o)));

  assert_row_move_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(row_o) |-> ($stable(col_o) || (int'($past(col_o)) == COLS - 1 && col_o == '0)));
endmodule

bind cursor_ctrl cursor_ctrl_chk #(.COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .dav_a_i (dav_a_i),
  .dav_b_i (dav_b_i),
  .phase_i (phase_i),
  .col_o   (col_o),
  .row_o   (row_o)
);

// File: tb/tb_cursor_ctrl.sv
`timescale 1ns/1ps
module tb_cursor_ctrl;
  localparam int COLS = 80;
  localparam int ROWS = 12;
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic dav_a = 1'b0, dav_b = 1'b0, defeat = 1'b0;
  logic [6:0] ch = 7'h00;
  logic [2:0] ph = 3'd0;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R2";

  always #5 clk = ~clk;

  cursor_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .dav_a_i(dav_a), .dav_b_i(dav_b),
    .char_i(ch), .phase_i(ph), .adv_defeat_i(defeat), .col_o(col), .row_o(row)
  );

  // behavioural reference
  int m_col = 0, m_row = 0;
  bit m_dq = 0, m_done = 0, m_ctl = 0, m_cr = 0, m_lf = 0, m_bs = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_col = 0; m_row = 0; m_dq = 0; m_done = 0;
      m_ctl = 0; m_cr = 0; m_lf = 0; m_bs = 0;
    end else begin
      bit d;
      d = dav_a || dav_b;
      if (d && !m_dq) begin
        m_done = 0; m_ctl = 0; m_cr = 0; m_lf = 0; m_bs = 0;
      end
      if (ph == 3'd2 && d && !m_done) begin
        m_done = 1;
        if (m_ctl) begin
          if (m_cr) m_col = 0;
          if (m_bs && m_col > 0) m_col = m_col - 1;
          if (m_lf) m_row = (m_row + 1) % ROWS;
        end else if (!defeat) begin
          m_col = m_col + 1;
          if (m_col == COLS) begin
            m_col = 0;
            m_row = (m_row + 1) % ROWS;
          end
        end
      end
      if (ph == 3'd1 && d) begin
        m_ctl = (ch < 7'h20) || (ch == 7'h7F);
        m_cr = (ch == 7'h0D);
        m_lf = (ch == 7'h0A);
        m_bs = (ch == 7'h08);
      end
      m_dq = d;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (int'(col) != m_col || int'(row) != m_row) begin
        errors++;
        $display("FAIL %s per-cycle: actual col=%0d row=%0d expected col=%0d row=%0d",
                 cur_req, col, row, m_col, m_row);
      end
    end
  end

  task automatic expect_pos(input string req, input int c, input int r);
    checks++;
    if (int'(col) != c || int'(row) != r) begin
      errors++;
      $display("FAIL %s: actual col=%0d row=%0d expected col=%0d row=%0d", req, col, row, c, r);
    end
  endtask

  task automatic send(input logic [6:0] c, input bit use_b);
    @(negedge clk);
    ch = c; ph = 3'd0;
    if (use_b) dav_b = 1'b1; else dav_a = 1'b1;
    @(negedge clk); ph = 3'd1;
    @(negedge clk); ph = 3'd2;
    @(negedge clk); ph = 3'd0;
    @(negedge clk); dav_a = 1'b0; dav_b = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #1;
    expect_pos("R2", 0, 0);
    repeat (3) @(negedge clk);
    expect_pos("R2", 0, 0);
    rst_n = 1'b1;

    cur_req = "R3"; send(7'h41, 0); expect_pos("R3", 1, 0);
    cur_req = "R1"; send(7'h42, 1); expect_pos("R1", 2, 0);

    cur_req = "R7";
    send(7'h08, 0); expect_pos("R7", 1, 0);
    send(7'h08, 1); expect_pos("R7", 0, 0);
    send(7'h08, 0); expect_pos("R7", 0, 0);

    cur_req = "R3";
    for (int i = 0; i < 5; i++) send(7'h61, i[0]);
    expect_pos("R3", 5, 0);
    cur_req = "R6"; send(7'h0A, 0); expect_pos("R6", 5, 1);
    cur_req = "R5"; send(7'h0D, 0); expect_pos("R5", 0, 1);

    cur_req = "R8";
    send(7'h07, 0); expect_pos("R8", 0, 1);
    send(7'h7F, 1); expect_pos("R8", 0, 1);
    send(7'h1B, 0); expect_pos("R8", 0, 1);

    cur_req = "R9";
    defeat = 1'b1;
    send(7'h78, 0); expect_pos("R9", 0, 1);
    send(7'h0A, 0); expect_pos("R9", 0, 2);
    @(negedge clk); defeat = 1'b0;

    cur_req = "R10";
    @(negedge clk); ph = 3'd2; ch = 7'h41;
    repeat (3) @(negedge clk);
    expect_pos("R10", 0, 2);
    ph = 3'd5; dav_a = 1'b1;
    @(negedge clk); ph = 3'd1;
    @(negedge clk); ph = 3'd7;
    @(negedge clk); expect_pos("R10", 0, 2);
    ph = 3'd0; dav_a = 1'b0;
    @(negedge clk);

    cur_req = "R12";
    ch = 7'h51; dav_b = 1'b1;
    @(negedge clk); ph = 3'd1;
    @(negedge clk); ph = 3'd2;
    @(negedge clk); ph = 3'd0;
    @(negedge clk); ph = 3'd2;
    @(negedge clk); ph = 3'd2;
    @(negedge clk); ph = 3'd0;
    expect_pos("R12", 1, 2);
    @(negedge clk); dav_b = 1'b0;
    @(negedge clk);

    cur_req = "R11";
    send(7'h0D, 0); expect_pos("R11", 0, 2);
    ch = 7'h0D; dav_a = 1'b1;
    @(negedge clk); ph = 3'd2;
    @(negedge clk); ph = 3'd0;
    expect_pos("R11", 1, 2);
    @(negedge clk); dav_a = 1'b0;
    @(negedge clk);

    cur_req = "R4";
    for (int i = 0; i < 78; i++) send(7'h2E, 0);
    expect_pos("R4", 79, 2);
    send(7'h2E, 1); expect_pos("R4", 0, 3);

    cur_req = "R6";
    for (int i = 0; i < 8; i++) send(7'h0A, 0);
    expect_pos("R6", 0, 11);
    send(7'h0A, 1); expect_pos("R6", 0, 0);

    cur_req = "R4";
    send(7'h0A, 0); send(7'h0A, 0);
    for (int i = 0; i < 8; i++) send(7'h0A, 0);
    expect_pos("R4", 0, 10);
    send(7'h0A, 0); expect_pos("R4", 0, 11);
    for (int i = 0; i < 79; i++) send(7'h23, 1);
    expect_pos("R4", 79, 11);
    send(7'h23, 0); expect_pos("R4", 0, 0);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule